// File: doc/BRIEF.md
# Dot-Matrix Style LCD Pixel Renderer

This block paints a low-resolution monochrome dot image onto an 800x480 colour LCD so that the picture keeps the look of a plasma dot display. An external timing generator supplies the pixel clock, the current column and row of the panel raster, and a data-enable flag. For every raster position the block works out whether the pixel lies in the surrounding frame, in a dark gap between dots, on a clipped dot corner, or on the lit part of a dot. Only in the last case does it read the dot's 2-bit intensity from a dual-port frame buffer with a one-clock read.

Source images are either 128 dots wide by 64 rows tall or 128 by 32, chosen by a mode input. Each dot becomes a 6x6 pixel cell: a 5x5 lit area with a one-pixel gap on its right and bottom edges. Its four outer corner pixels take the gap colour, which gives the dots a rounded look. The image is centred on the panel. Intensities are turned into colour through one of four software-written palettes of four 24-bit entries each. The frame around the image uses a colour taken from an input.

Top module: `dotlcd_render`

## Requirements
- R1: `rgb_out` and `de_out` for a raster position appear exactly 2 clocks after `pix_x`, `pix_y` and `pix_de` are presented, and `de_out` equals `pix_de` delayed by 2 clocks.
- R2: In tall mode (`mode_tall`=1) the image spans x 16..783 and y 48..431. In short mode (`mode_tall`=0) it spans x 16..783 and y 144..335. Every enabled pixel outside it shows `frame_rgb`.
- R3: Dot (c,r) occupies cell x 16+6c..16+6c+5 and y yoff+6r..yoff+6r+5. A pixel at cell offset 5 in x or y is a gap and shows entry 0 of the active palette.
- R4: Pixels at cell offsets (0,0), (0,4), (4,0) and (4,4) show entry 0 of the active palette.
- R5: `fb_rd` is high only for enabled, non-gap, non-corner image pixels. Its `fb_addr` is r*128+c, and `fb_data` is taken one clock after the read.
- R6: A lit pixel shows the palette entry indexed by its 2-bit intensity, so intensity 0 shows entry 0.
- R7: When `cfg_we` is high at a clock edge, `cfg_data` is stored in entry `cfg_addr[1:0]` of palette `cfg_addr[3:2]`.
- R8: After reset `rgb_out`, `de_out` and `fb_rd` (with `pix_de` low) are 0, and entry e of every palette is e*0x555555.
- R9: Whenever `de_out` is low, `rgb_out` is 0.
- R10: `pal_sel` chooses which of the four palettes colours the gaps, corners and dots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tall | input | 1 | 1: 128x64 source, 0: 128x32 source |
| pal_sel | input | 2 | Active palette |
| frame_rgb | input | 24 | Colour of the area around the image |
| cfg_we | input | 1 | Palette write strobe |
| cfg_addr | input | 4 | Palette (bits 3:2) and entry (bits 1:0) |
| cfg_data | input | 24 | Palette entry RGB value |
| pix_x | input | 10 | Current raster column |
| pix_y | input | 10 | Current raster row |
| pix_de | input | 1 | Raster position is visible |
| fb_rd | output | 1 | Frame buffer read enable |
| fb_addr | output | 13 | Frame buffer dot address |
| fb_data | input | 2 | Dot intensity, one clock after the read |
| rgb_out | output | 24 | Pixel colour {R,G,B} |
| de_out | output | 1 | Delayed data enable |

## Verification
Every coloured result and `de_out` is due two rising edges after its coordinates are driven. The driver pushes each expected item tagged with its due cycle number, and the monitor compares it at the falling edge of exactly that cycle. Frame buffer read enable and address respond within the same cycle, so they are checked 1 ns after the coordinates change. Palette and mode inputs are changed only after the pipeline has drained, so that no item in flight sees a mix of settings.

// File: rtl/dotlcd_pkg.sv
package dotlcd_pkg;
    typedef logic [23:0] rgb_t;
    typedef enum logic [1:0] {
        CLS_FRAME = 2'd0,
        CLS_GAP   = 2'd1,
        CLS_DOT   = 2'd2
    } pix_cls_e;
endpackage

// File: rtl/dotlcd_locate.sv
module dotlcd_locate
    import dotlcd_pkg::*;
#(
    parameter int H_RES    = 800,
    parameter int V_RES    = 480,
    parameter int COLS     = 128,
    parameter int ROWS_MAX = 64,
    parameter int CELL     = 6,
    parameter int LIT      = 5,
    parameter int PW       = 10,
    parameter int AW       = 13
) (
    input  logic          mode_tall,
    input  logic [PW-1:0] pix_x,
    input  logic [PW-1:0] pix_y,
    input  logic          pix_de,
    output pix_cls_e      cls,
    output logic          fb_rd,
    output logic [AW-1:0] fb_addr
);
    localparam int IMG_W      = COLS * CELL;
    localparam int TALL_H     = ROWS_MAX * CELL;
    localparam int SHORT_H    = (ROWS_MAX / 2) * CELL;
    localparam logic [PW-1:0] XOFF     = PW'((H_RES - IMG_W) / 2);
    localparam logic [PW-1:0] XEND     = PW'((H_RES - IMG_W) / 2 + IMG_W);
    localparam logic [PW-1:0] YOFF_T   = PW'((V_RES - TALL_H) / 2);
    localparam logic [PW-1:0] YOFF_S   = PW'((V_RES - SHORT_H) / 2);
    localparam logic [PW-1:0] H_T      = PW'(TALL_H);
    localparam logic [PW-1:0] H_S      = PW'(SHORT_H);
    localparam logic [PW-1:0] CELL_V   = PW'(CELL);
    localparam logic [PW-1:0] LIT_V    = PW'(LIT);
    localparam logic [PW-1:0] EDGE_V   = PW'(LIT - 1);

    logic [PW-1:0] yoff, yend, rel_x, rel_y, col_w, row_w, sub_x, sub_y;
    logic          in_img, gap, corner;

    always_comb begin
        yoff   = mode_tall ? YOFF_T : YOFF_S;
        yend   = yoff + (mode_tall ? H_T : H_S);
        in_img = (pix_x >= XOFF) && (pix_x < XEND) && (pix_y >= yoff) && (pix_y < yend);
        rel_x  = pix_x - XOFF;
        rel_y  = pix_y - yoff;
        col_w  = rel_x / CELL_V;
        row_w  = rel_y / CELL_V;
        sub_x  = rel_x % CELL_V;
        sub_y  = rel_y % CELL_V;
        gap    = (sub_x >= LIT_V) || (sub_y >= LIT_V);
        corner = ((sub_x == '0) || (sub_x == EDGE_V)) && ((sub_y == '0) || (sub_y == EDGE_V));
        if (!in_img)            cls = CLS_FRAME;
        else if (gap || corner) cls = CLS_GAP;
        else                    cls = CLS_DOT;
        fb_rd   = pix_de && (cls == CLS_DOT);
        fb_addr = AW'(row_w) * AW'(COLS) + AW'(col_w);
    end
endmodule

// File: rtl/dotlcd_palette.sv
module dotlcd_palette
    import dotlcd_pkg::*;
#(
    parameter int NPAL = 4,
    parameter int NENT = 4,
    parameter int PSW  = $clog2(NPAL),
    parameter int ESW  = $clog2(NENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [PSW+ESW-1:0] cfg_addr,
    input  logic [23:0]        cfg_data,
    input  logic [PSW-1:0]     rd_pal,
    input  logic [ESW-1:0]     rd_ent,
    output rgb_t               rd_rgb
);
    localparam int TOTAL = NPAL * NENT;

    rgb_t pal_d [TOTAL];
    rgb_t pal_q [TOTAL];

    function automatic rgb_t reset_entry(int idx);
        logic [7:0] lvl;
        lvl = 8'((idx % NENT) * (255 / (NENT - 1)));
        return {lvl, lvl, lvl};
    endfunction

    always_comb begin
        for (int i = 0; i < TOTAL; i++) pal_d[i] = pal_q[i];
        if (cfg_we) pal_d[cfg_addr] = cfg_data;
        rd_rgb = pal_q[{rd_pal, rd_ent}];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) pal_q[i] <= reset_entry(i);
        end else begin
            for (int i = 0; i < TOTAL; i++) pal_q[i] <= pal_d[i];
        end
    end

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (pal_q[$past(cfg_addr)] == $past(cfg_data))); // R7
endmodule

// File: rtl/dotlcd_render.sv
module dotlcd_render
    import dotlcd_pkg::*;
#(
    parameter int H_RES    = 800,
    parameter int V_RES    = 480,
    parameter int COLS     = 128,
    parameter int ROWS_MAX = 64,
    parameter int CELL     = 6,
    parameter int LIT      = 5,
    parameter int NPAL     = 4,
    parameter int NENT     = 4,
    parameter int PW       = $clog2(H_RES),
    parameter int AW       = $clog2(COLS * ROWS_MAX),
    parameter int PSW      = $clog2(NPAL),
    parameter int ESW      = $clog2(NENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_tall,
    input  logic [PSW-1:0]     pal_sel,
    input  logic [23:0]        frame_rgb,
    input  logic               cfg_we,
    input  logic [PSW+ESW-1:0] cfg_addr,
    input  logic [23:0]        cfg_data,
    input  logic [PW-1:0]      pix_x,
    input  logic [PW-1:0]      pix_y,
    input  logic               pix_de,
    output logic               fb_rd,
    output logic [AW-1:0]      fb_addr,
    input  logic [ESW-1:0]     fb_data,
    output logic [23:0]        rgb_out,
    output logic               de_out
);
    typedef struct packed {
        pix_cls_e cls;
        logic     de;
        rgb_t     rgb;
        logic     de_o;
    } pipe_t;

    pipe_t          s_d, s_q;
    pix_cls_e       cls_loc;
    logic [ESW-1:0] ent;
    rgb_t           pal_rgb;

    dotlcd_locate #(
        .H_RES(H_RES), .V_RES(V_RES), .COLS(COLS), .ROWS_MAX(ROWS_MAX),
        .CELL(CELL), .LIT(LIT), .PW(PW), .AW(AW)
    ) u_locate (
        .mode_tall(mode_tall), .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
        .cls(cls_loc), .fb_rd(fb_rd), .fb_addr(fb_addr)
    );

    dotlcd_palette #(.NPAL(NPAL), .NENT(NENT), .PSW(PSW), .ESW(ESW)) u_palette (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .rd_pal(pal_sel), .rd_ent(ent), .rd_rgb(pal_rgb)
    );

    always_comb begin
        s_d     = s_q;
        s_d.cls = cls_loc;
        s_d.de  = pix_de;
        ent     = (s_q.cls == CLS_DOT) ? fb_data : '0;
        if (!s_q.de)                  s_d.rgb = '0;
        else if (s_q.cls == CLS_FRAME) s_d.rgb = frame_rgb;
        else                          s_d.rgb = pal_rgb;
        s_d.de_o = s_q.de;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{cls: CLS_FRAME, de: 1'b0, rgb: '0, de_o: 1'b0};
        else        s_q <= s_d;
    end

    assign rgb_out = s_q.rgb;
    assign de_out  = s_q.de_o;

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= '0;
        else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

    AST_DE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (de_out == $past(pix_de, 2))); // R1
    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !de_out |-> (rgb_out == '0)); // R9
    AST_READ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd |-> pix_de); // R5
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd |-> (int'(fb_addr) < (mode_tall ? COLS * ROWS_MAX : COLS * ROWS_MAX / 2))); // R5
endmodule

// File: tb/dotlcd_render_test.sv
module dotlcd_render_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_tall = 1'b1;
    logic [1:0]  pal_sel = 2'd0;
    logic [23:0] frame_rgb = 24'h102030;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [23:0] cfg_data = '0;
    logic [9:0]  pix_x = '0, pix_y = '0;
    logic        pix_de = 1'b0;
    logic        fb_rd;
    logic [12:0] fb_addr;
    logic [1:0]  fb_data = '0;
    logic [23:0] rgb_out;
    logic        de_out;

    always #10 clk = ~clk;

    dotlcd_render uut (
        .clk(clk), .rst_n(rst_n), .mode_tall(mode_tall), .pal_sel(pal_sel),
        .frame_rgb(frame_rgb), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de), .fb_rd(fb_rd), .fb_addr(fb_addr),
        .fb_data(fb_data), .rgb_out(rgb_out), .de_out(de_out)
    );

    logic [1:0]  fbm [8192];
    logic [23:0] pal_m [4][4];
    always @(posedge clk) if (fb_rd) fb_data <= fbm[fb_addr];

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [23:0] rgb;
        logic        de;
        string       tag;
    } item_t;
    item_t sb[$];

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(int x, int y, bit de, output logic [23:0] rgb, output string tag);
        int yoff, rows, c, r, sx, sy;
        yoff = mode_tall ? 48 : 144;
        rows = mode_tall ? 64 : 32;
        if (!de) begin rgb = '0; tag = "R9"; end
        else if (x < 16 || x >= 784 || y < yoff || y >= yoff + rows * 6) begin
            rgb = frame_rgb; tag = "R2";
        end else begin
            c = (x - 16) / 6; sx = (x - 16) % 6;
            r = (y - yoff) / 6; sy = (y - yoff) % 6;
            if (sx == 5 || sy == 5) begin rgb = pal_m[pal_sel][0]; tag = "R3"; end
            else if ((sx == 0 || sx == 4) && (sy == 0 || sy == 4)) begin
                rgb = pal_m[pal_sel][0]; tag = "R4";
            end else begin rgb = pal_m[pal_sel][fbm[r * 128 + c]]; tag = "R6"; end
        end
    endfunction

    task automatic drive_px(int x, int y, bit de);
        item_t it;
        @(negedge clk);
        pix_x = 10'(x); pix_y = 10'(y); pix_de = de;
        model(x, y, de, it.rgb, it.tag);
        it.de = de;
        it.due = cyc + 2;
        sb.push_back(it);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) drive_px(0, 0, 1'b0);
    endtask

    task automatic scan(int y, int x0, int x1);
        for (int x = x0; x <= x1; x++) drive_px(x, y, 1'b1);
    endtask

    task automatic chk_fb(int x, int y, bit exp_rd, int exp_addr);
        drive_px(x, y, 1'b1);
        #1;
        check(fb_rd == exp_rd, "R5 fb_rd", 32'(fb_rd), 32'(exp_rd));
        if (exp_rd) check(fb_addr == 13'(exp_addr), "R5 fb_addr", 32'(fb_addr), 32'(exp_addr));
    endtask

    task automatic cfg_write(int p, int e, logic [23:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(p * 4 + e); cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
        pal_m[p][e] = v;
    endtask

    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check(de_out == it.de, "R1 de_out", 32'(de_out), 32'(it.de));
            check(rgb_out == it.rgb, it.tag, 32'(rgb_out), 32'(it.rgb));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 8192; a++) fbm[a] = 2'((a ^ (a >> 7) ^ (a >> 2)) & 3);
        for (int p = 0; p < 4; p++)
            for (int e = 0; e < 4; e++) pal_m[p][e] = {3{8'(e * 85)}};
        repeat (3) @(negedge clk);
        // R8: reset state at the ports
        check(rgb_out == '0, "R8 rgb", 32'(rgb_out), 0);
        check(de_out == 1'b0, "R8 de", 32'(de_out), 0);
        check(fb_rd == 1'b0, "R8 fb_rd", 32'(fb_rd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: default palette through dots and gaps
        scan(50, 14, 60);
        drain();
        // R7: write distinct palettes
        for (int p = 0; p < 4; p++)
            for (int e = 0; e < 4; e++)
                cfg_write(p, e, {8'(p * 60 + e * 50), 8'(e * 70 + 5), 8'(255 - p * 40 - e * 10)});
        drain();
        // R2 R3 R4 R6: tall mode, several rows and edges
        scan(47, 10, 30);
        scan(48, 10, 40);
        scan(49, 10, 40);
        scan(52, 10, 40);
        scan(53, 10, 40);
        scan(200, 770, 799);
        scan(431, 770, 799);
        scan(432, 770, 790);
        drain();
        // R5: read enable and address
        chk_fb(18, 50, 1'b1, 0);
        chk_fb(16, 48, 1'b0, 0);
        chk_fb(21, 50, 1'b0, 0);
        chk_fb(15, 50, 1'b0, 0);
        chk_fb(16 + 6 * 127 + 2, 48 + 6 * 63 + 2, 1'b1, 63 * 128 + 127);
        chk_fb(16 + 6 * 5 + 1, 48 + 6 * 3 + 3, 1'b1, 3 * 128 + 5);
        drain();
        // R10: other palettes
        pal_sel = 2'd2;
        scan(51, 16, 60);
        drain();
        pal_sel = 2'd3;
        scan(300, 400, 440);
        drain();
        // R2: short mode boundaries and a new frame colour
        mode_tall = 1'b0;
        frame_rgb = 24'hABCDEF;
        scan(143, 10, 30);
        scan(144, 10, 40);
        scan(146, 10, 40);
        scan(335, 770, 799);
        scan(336, 770, 790);
        scan(60, 100, 110);
        chk_fb(18, 146, 1'b1, 0);
        chk_fb(18 + 6 * 2, 146 + 6 * 31, 1'b1, 31 * 128 + 2);
        chk_fb(18, 60, 1'b0, 0);
        drain();
        // R9: disabled pixels inside the image stay black
        for (int x = 16; x < 40; x++) drive_px(x, 150, 1'b0);
        drain();
        // R7: rewrite one entry and see it on lit dots
        cfg_write(3, 0, 24'h00FF00);
        cfg_write(3, 2, 24'hFF0000);
        scan(147, 16, 100);
        drain();
        drain();
        finish_run();
    end
endmodule